// File: doc/BRIEF.md
# Serial EEPROM Transfer Engine

This block is a two-wire bus master that moves a run of bytes between the chip and a small serial EEPROM. A client gives it a request: a start offset, a byte count and a direction. Write data arrives on a byte-wide valid/ready stream, and read data leaves on a second one. When the transfer ends, the engine gives a one-cycle completion pulse with an error flag.

A chain-type input selects one of two addressing styles, and it is sampled when a request is taken. In the legacy style there is no device address on the wire. The first byte carries the memory offset itself, with the direction in its low bit. In the standard style the first byte holds the device address, and the offset follows as its own byte. A standard-style read therefore sets the device's pointer with a write header, ends that frame, and opens a new frame to read. Writes are cut into short bursts. After each burst the engine polls the device with read headers until the device acknowledges, then reads and discards one byte before it moves on.

Both bus lines are open-drain: the engine only pulls them low or lets them go. A parameterised divider paces every line change. Bus recovery and device probing are left to other logic.

Top module: `eep_xfer_engine`

## Requirements
- R1: While reset is held, and right after it, both lines are released, `req_ready` is high and `xfer_done` is low.
- R2: Bytes go MSB first. Inside a byte, the data line changes only while the clock line is held low. A frame opens with the data line falling while the clock line is high (START), and closes with the data line rising while the clock line is high (STOP).
- R3: In legacy style the first byte of a frame is `{offset[6:0], rw}`, where rw is 1 for a read and 0 for a write.
- R4: A standard-style read sends `{DEV_ADDR,0}`, then the offset byte, then STOP. It then sends START, then `{DEV_ADDR,1}`, and then reads data. A whole read therefore uses two STARTs and two STOPs.
- R5: In a read of N bytes, the engine acknowledges the first N-1 bytes and not the last. Bytes leave on the read stream in address order, and `rd_valid` with `rd_data` holds steady until `rd_ready` is seen.
- R6: A write is split into bursts of at most BURST (default 4) data bytes. Each burst has its own START, address phase and STOP, and starts at the offset where the previous burst ended.
- R7: After each write burst, the engine repeats START plus `{DEV_ADDR,1}` and, on no acknowledge, STOP. It does this until the device acknowledges, then reads one byte without acknowledging it and sends STOP. After POLL_MAX (default 100) unacknowledged tries it ends with an error.
- R8: A missing acknowledge on an address, offset or data byte ends the transfer with STOP and an error. No further bytes go out and no burst is completed.
- R9: Any two changes on the bus lines are at least CLK_DIV clock cycles apart.
- R10: A request with length zero completes, without error, within one cycle of being taken and makes no bus activity.
- R11: `xfer_done` lasts exactly one cycle, and both lines are released while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| legacy_chain | input | 1 | 1 selects legacy addressing, 0 standard |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken this cycle if offered |
| req_write | input | 1 | 1 write, 0 read |
| req_offset | input | 8 | Start offset in the EEPROM |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Engine takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Client takes read byte |
| rd_data | output | 8 | Read byte |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Error status, valid with xfer_done |
| scl_low | output | 1 | 1 pulls the clock line low |
| sda_low | output | 1 | 1 pulls the data line low |
| sda_in | input | 1 | Sensed level of the data line |

## Verification
A wrong step counter or a slipped bit index in the bus layer shows up within one byte time. It appears as a spurious START or STOP seen by the device model, or as a shifted byte in the scoreboard. Faulty sequencing shows up as the wrong list of header bytes or the wrong START/STOP counts by the end of that transfer. That covers a lost offset phase, an extra burst byte, or an ack sent on the last read byte. A broken poll counter shows up only at the end of a long busy period, so one test keeps the device busy past the poll limit and counts the exact number of refused headers.

// File: rtl/eep_xfer_pkg.sv
package eep_xfer_pkg;

  typedef enum logic [1:0] {
    BOP_START,
    BOP_STOP,
    BOP_WRITE,
    BOP_READ
  } bus_op_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_A_START,
    S_A_ADDR,
    S_A_OFF,
    S_R_STOP1,
    S_R_START2,
    S_R_ADDR2,
    S_R_BYTE,
    S_R_PUSH,
    S_W_FETCH,
    S_W_BYTE,
    S_W_STOP,
    S_P_START,
    S_P_ADDR,
    S_P_NSTOP,
    S_P_READ,
    S_P_STOP,
    S_END_STOP,
    S_FIN
  } seq_state_e;

  // First byte of a frame: offset-carrying in legacy style, device address otherwise.
  function automatic logic [7:0] header_byte(input logic legacy, input logic [6:0] dev,
                                             input logic [7:0] off, input logic rd);
    return legacy ? {off[6:0], rd} : {dev, rd};
  endfunction

  // Level for bit slot idx (0..8) of a byte op; 1 means release the line.
  function automatic logic slot_release(input logic is_wr, input logic [7:0] d,
                                        input logic [3:0] idx, input logic give_ack);
    if (idx == 4'd8) return is_wr ? 1'b1 : !give_ack;
    return is_wr ? d[3'(4'd7 - idx)] : 1'b1;
  endfunction

endpackage

// File: rtl/eep_tick_gen.sv
module eep_tick_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (tick) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  generate
    if (CLK_DIV > 1) begin : g_gap
      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/eep_bus_phy.sv
module eep_bus_phy
  import eep_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_ack,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_seen,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in
);
  localparam logic [3:0] LAST_SLOT = 4'd8;

  bus_op_e    op;
  logic [7:0] data;
  logic       give_ack;
  logic [3:0] slot;
  logic [1:0] step;
  logic [8:0] sh;
  logic       is_byte;
  logic       last_step;

  assign is_byte   = (op == BOP_WRITE) || (op == BOP_READ);
  assign last_step = is_byte ? (step == 2'd2 && slot == LAST_SLOT) : (step == 2'd3);
  assign rx_byte   = sh[8:1];
  assign ack_seen  = !sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; op <= BOP_START; data <= '0; give_ack <= 1'b0;
      slot <= '0; step <= '0; sh <= '0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy <= 1'b1; op <= cmd_op; data <= cmd_data; give_ack <= cmd_ack;
          slot <= '0; step <= '0;
        end
      end else if (tick) begin
        unique case (op)
          BOP_START: begin
            unique case (step)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: scl_low <= 1'b1;
            endcase
          end
          BOP_STOP: begin
            unique case (step)
              2'd0: scl_low <= 1'b1;
              2'd1: sda_low <= 1'b1;
              2'd2: scl_low <= 1'b0;
              default: sda_low <= 1'b0;
            endcase
          end
          default: begin
            unique case (step)
              2'd0: sda_low <= !slot_release(op == BOP_WRITE, data, slot, give_ack);
              2'd1: scl_low <= 1'b0;
              default: begin
                sh      <= {sh[7:0], sda_in};
                scl_low <= 1'b1;
              end
            endcase
          end
        endcase
        if (is_byte && step == 2'd2) begin
          step <= '0;
          slot <= slot + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_scl_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_low) |-> $past(tick));
  p_sda_paced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> $past(tick));
  p_data_under_low_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_byte && !$stable(sda_low)) |-> (scl_low && $past(scl_low)));
  p_cmd_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/eep_xfer_engine.sv
module eep_xfer_engine
  import eep_xfer_pkg::*;
#(
  parameter int         CLK_DIV  = 8,
  parameter int         LEN_W    = 8,
  parameter int         BURST    = 4,
  parameter int         POLL_MAX = 100,
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_chain,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             xfer_done,
  output logic             xfer_err,
  output logic             scl_low,
  output logic             sda_low,
  input  logic             sda_in
);
  localparam int BW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

  seq_state_e       state;
  logic             legacy_q, is_wr, err_q, pend;
  logic [LEN_W-1:0] left;
  logic [7:0]       off, wbyte;
  logic [BW-1:0]    bcnt;
  logic [PW-1:0]    poll;

  logic             tick;
  logic             bus_state, cmd_valid, cmd_ack;
  bus_op_e          cmd_op;
  logic [7:0]       cmd_data;
  logic             eng_busy, eng_done, eng_ack;
  logic [7:0]       eng_rx;
  logic             last_byte, burst_full;

  eep_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  eep_bus_phy u_phy (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx), .ack_seen(eng_ack),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in)
  );

  assign last_byte  = (left == LEN_W'(1));
  assign burst_full = (bcnt == BW'(BURST - 1));

  always_comb begin
    cmd_op    = BOP_START;
    cmd_data  = '0;
    cmd_ack   = 1'b0;
    bus_state = 1'b1;
    unique case (state)
      S_A_START, S_R_START2, S_P_START: cmd_op = BOP_START;
      S_R_STOP1, S_W_STOP, S_P_NSTOP, S_P_STOP, S_END_STOP: cmd_op = BOP_STOP;
      S_A_ADDR: begin
        cmd_op   = BOP_WRITE;
        cmd_data = header_byte(legacy_q, DEV_ADDR, off, legacy_q && !is_wr);
      end
      S_A_OFF: begin
        cmd_op   = BOP_WRITE;
        cmd_data = off;
      end
      S_R_ADDR2, S_P_ADDR: begin
        cmd_op   = BOP_WRITE;
        cmd_data = {DEV_ADDR, 1'b1};
      end
      S_R_BYTE: begin
        cmd_op  = BOP_READ;
        cmd_ack = !last_byte;
      end
      S_W_BYTE: begin
        cmd_op   = BOP_WRITE;
        cmd_data = wbyte;
      end
      S_P_READ: cmd_op = BOP_READ;
      default: bus_state = 1'b0;
    endcase
  end

  assign cmd_valid = bus_state && !pend;
  assign req_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_W_FETCH);
  assign rd_valid  = (state == S_R_PUSH);
  assign xfer_done = (state == S_FIN);
  assign xfer_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; legacy_q <= 1'b0; is_wr <= 1'b0; err_q <= 1'b0; pend <= 1'b0;
      left <= '0; off <= '0; wbyte <= '0; bcnt <= '0; poll <= '0; rd_data <= '0;
    end else begin
      if (cmd_valid) pend <= 1'b1;
      if (eng_done) begin
        pend <= 1'b0;
        unique case (state)
          S_A_START:  state <= S_A_ADDR;
          S_A_ADDR: begin
            if (!eng_ack)      begin err_q <= 1'b1; state <= S_END_STOP; end
            else if (!legacy_q) state <= S_A_OFF;
            else               state <= is_wr ? S_W_FETCH : S_R_BYTE;
          end
          S_A_OFF: begin
            if (!eng_ack) begin err_q <= 1'b1; state <= S_END_STOP; end
            else          state <= is_wr ? S_W_FETCH : S_R_STOP1;
          end
          S_R_STOP1:  state <= S_R_START2;
          S_R_START2: state <= S_R_ADDR2;
          S_R_ADDR2: begin
            if (!eng_ack) begin err_q <= 1'b1; state <= S_END_STOP; end
            else          state <= S_R_BYTE;
          end
          S_R_BYTE: begin
            rd_data <= eng_rx;
            state   <= S_R_PUSH;
          end
          S_W_BYTE: begin
            if (!eng_ack) begin
              err_q <= 1'b1;
              state <= S_END_STOP;
            end else begin
              left <= left - 1'b1;
              off  <= off + 1'b1;
              if (last_byte || burst_full) begin
                bcnt  <= '0;
                state <= S_W_STOP;
              end else begin
                bcnt  <= bcnt + 1'b1;
                state <= S_W_FETCH;
              end
            end
          end
          S_W_STOP: begin
            poll  <= '0;
            state <= S_P_START;
          end
          S_P_START: state <= S_P_ADDR;
          S_P_ADDR:  state <= eng_ack ? S_P_READ : S_P_NSTOP;
          S_P_NSTOP: begin
            if (poll == PW'(POLL_MAX - 1)) begin
              err_q <= 1'b1;
              state <= S_FIN;
            end else begin
              poll  <= poll + 1'b1;
              state <= S_P_START;
            end
          end
          S_P_READ:   state <= S_P_STOP;
          S_P_STOP:   state <= (left == '0) ? S_FIN : S_A_START;
          S_END_STOP: state <= S_FIN;
          default:    state <= state;
        endcase
      end else begin
        unique case (state)
          S_IDLE: begin
            if (req_valid) begin
              legacy_q <= legacy_chain;
              is_wr    <= req_write;
              off      <= req_offset;
              left     <= req_len;
              bcnt     <= '0;
              err_q    <= 1'b0;
              state    <= (req_len == '0) ? S_FIN : S_A_START;
            end
          end
          S_W_FETCH: begin
            if (wr_valid) begin
              wbyte <= wr_data;
              state <= S_W_BYTE;
            end
          end
          S_R_PUSH: begin
            if (rd_ready) begin
              left  <= left - 1'b1;
              state <= last_byte ? S_END_STOP : S_R_BYTE;
            end
          end
          S_FIN:   state <= S_IDLE;
          default: state <= state;
        endcase
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  p_done_bus_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!scl_low && !sda_low));
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_burst_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_W_BYTE) |-> (32'(bcnt) < BURST));
  p_poll_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_P_NSTOP) |-> (32'(poll) < POLL_MAX));
  p_cmd_idle_phy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !eng_busy);
  p_req_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!eng_busy && !rd_valid && !wr_ready));
endmodule

// File: tb/eep_xfer_engine_test.sv
module eep_xfer_engine_test;
  localparam int         DIV   = 4;
  localparam int         POLLS = 100;
  localparam logic [6:0] DEV   = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       legacy_chain = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_offset = '0, req_len = '0;
  logic       wr_valid = 1'b0, rd_ready = 1'b1;
  logic [7:0] wr_data = '0;
  logic       req_ready, wr_ready, rd_valid, xfer_done, xfer_err, scl_low, sda_low, sda_in;
  logic [7:0] rd_data;
  logic       sl_low = 1'b0;

  assign sda_in = !(sda_low | sl_low);

  eep_xfer_engine #(.CLK_DIV(DIV), .LEN_W(8), .BURST(4), .POLL_MAX(POLLS), .DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .legacy_chain(legacy_chain),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in)
  );

  int vectors = 0, miscompares = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM device model ----------------
  logic [7:0] mem [128];
  logic [7:0] shadow [128];
  bit         sl_legacy = 0, nack_data = 0, mack = 0;
  logic [6:0] sl_dev = DEV, ptr = '0;
  int         sl_phase = 0, bc = 0, nxt = 0, busy_left = 0, busy_set = 0;
  logic [7:0] sh = '0, cur = '0;
  logic [6:0] pw_a [16];
  logic [7:0] pw_d [16];
  int         pw_n = 0;
  int         n_start = 0, n_stop = 0, n_busy_nack = 0, n_mack = 0, n_mnack = 0;
  int         n_bursts = 0, max_burst = 0;
  logic [7:0] addr_log [$];
  bit         prev_scl = 1, prev_sda = 1;

  always @(negedge clk) begin
    bit scl_l, sda_l, ack;
    scl_l = !scl_low;
    sda_l = !(sda_low | sl_low);
    if (scl_l && prev_scl && prev_sda && !sda_l) begin
      n_start++; sl_phase = 1; bc = 0; pw_n = 0; sl_low = 0;
    end else if (scl_l && prev_scl && !prev_sda && sda_l) begin
      n_stop++;
      if (pw_n > 0) begin
        for (int i = 0; i < pw_n; i++) mem[pw_a[i]] = pw_d[i];
        n_bursts++;
        if (pw_n > max_burst) max_burst = pw_n;
        busy_left = busy_set;
      end
      pw_n = 0; sl_phase = 0; sl_low = 0;
    end else if (scl_l && !prev_scl) begin
      if (sl_phase != 0) begin
        if (bc < 8 && sl_phase != 4) sh = {sh[6:0], sda_l};
        if (bc == 8 && sl_phase == 4) begin
          mack = !sda_l;
          if (mack) n_mack++; else n_mnack++;
        end
        bc++;
      end
    end else if (!scl_l && prev_scl && sl_phase != 0) begin
      if (sl_phase == 4) begin
        if (bc >= 1 && bc <= 7) sl_low = !cur[7-bc];
        else if (bc == 8) sl_low = 0;
        else if (bc == 9) begin
          bc = 0;
          if (mack) begin ptr++; cur = mem[ptr]; sl_low = !cur[7]; end
          else begin sl_phase = 0; sl_low = 0; end
        end
      end else if (bc == 8) begin
        ack = 0; nxt = 0;
        if (sl_phase == 1) begin
          addr_log.push_back(sh);
          if (busy_left > 0) begin busy_left--; n_busy_nack++; end
          else if (sl_legacy) begin ptr = sh[7:1]; ack = 1; nxt = sh[0] ? 4 : 3; end
          else if (sh[7:1] == sl_dev) begin ack = 1; nxt = sh[0] ? 4 : 2; end
        end else if (sl_phase == 2) begin
          ptr = sh[6:0]; ack = 1; nxt = 3;
        end else if (!nack_data && pw_n < 16) begin
          pw_a[pw_n] = ptr; pw_d[pw_n] = sh; pw_n++; ptr++; ack = 1; nxt = 3;
        end
        sl_low = ack;
      end else if (bc == 9) begin
        sl_low = 0; bc = 0; sl_phase = nxt;
        if (nxt == 4) begin cur = mem[ptr]; sl_low = !cur[7]; end
      end
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  // ---------------- streams, scoreboard, pacing monitor ----------------
  logic [7:0] wq [$];
  logic [7:0] exp_q [$];
  bit take = 0, stall_en = 0;
  int last_chg = -1000, pace_viol = 0;
  bit last_scl = 0, last_sda = 0;

  always @(negedge clk) begin
    if (take) void'(wq.pop_front());
    wr_valid = (wq.size() > 0);
    wr_data  = (wq.size() > 0) ? wq[0] : 8'h00;
    take     = wr_valid && wr_ready;
    rd_ready = stall_en ? cyc[1] : 1'b1;
    if (rd_valid && rd_ready) begin
      if (exp_q.size() == 0) check(0, "R5", "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R5", "read data", rd_data, e);
      end
    end
    if (scl_low != last_scl || sda_low != last_sda) begin
      if (cyc - last_chg < DIV) pace_viol++;
      last_chg = cyc; last_scl = scl_low; last_sda = sda_low;
    end
  end

  task automatic clear_stats();
    n_start = 0; n_stop = 0; n_busy_nack = 0; n_mack = 0; n_mnack = 0;
    n_bursts = 0; max_burst = 0; addr_log.delete();
  endtask

  task automatic run(input bit wr, input bit leg, input logic [7:0] off, input int len,
                     output bit err, output int took);
    clear_stats();
    sl_legacy = leg;
    @(negedge clk);
    legacy_chain = leg; req_write = wr; req_offset = off; req_len = 8'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    took = 0;
    while (!xfer_done && took < 100000) begin @(negedge clk); took++; end
    err = xfer_err;
    check(!scl_low && !sda_low, "R11", "lines released at done", {scl_low, sda_low}, 0);
    @(negedge clk);
    check(!xfer_done, "R11", "done lasts one cycle", xfer_done, 0);
  endtask

  task automatic do_write(input bit leg, input logic [7:0] off, input int len, input logic [7:0] seed,
                          input bit keep, output bit err);
    int took;
    for (int i = 0; i < len; i++) begin
      wq.push_back(8'(seed + i * 37));
      if (keep) shadow[7'(off + i)] = 8'(seed + i * 37);
    end
    run(1, leg, off, len, err, took);
  endtask

  task automatic do_read(input bit leg, input logic [7:0] off, input int len, input bit expect_data,
                         output bit err);
    int took;
    if (expect_data) for (int i = 0; i < len; i++) exp_q.push_back(shadow[7'(off + i)]);
    run(0, leg, off, len, err, took);
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    check(0, "R1", "watchdog expired", wd, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit err;
    int took;
    for (int i = 0; i < 128; i++) begin mem[i] = 8'(i) ^ 8'h5A; shadow[i] = 8'(i) ^ 8'h5A; end
    repeat (4) @(negedge clk);
    check(!scl_low && !sda_low, "R1", "lines released in reset", {scl_low, sda_low}, 0);
    check(req_ready && !xfer_done, "R1", "ready, no done in reset", {req_ready, xfer_done}, 2);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !scl_low && !sda_low, "R1", "idle after reset", {req_ready, scl_low, sda_low}, 4);

    // R6 / R7: standard write of 6 bytes -> bursts of 4 and 2, each polled
    do_write(0, 8'h10, 6, 8'h21, 1, err);
    check(!err, "R6", "std write status", err, 0);
    check(n_bursts == 2, "R6", "burst count", n_bursts, 2);
    check(max_burst == 4, "R6", "largest burst", max_burst, 4);
    check(addr_log.size() == 4, "R7", "header count", addr_log.size(), 4);
    check(addr_log[1] == {DEV, 1'b1}, "R7", "poll header", addr_log[1], {DEV, 1'b1});
    check(n_start == 4 && n_stop == 4, "R2", "frame marks on write", n_start * 16 + n_stop, 68);
    check(n_mnack == 2 && n_mack == 0, "R7", "poll byte not acked", n_mnack, 2);

    // R4 / R5: standard read of 6 with a stalling reader
    stall_en = 1;
    do_read(0, 8'h10, 6, 1, err);
    stall_en = 0;
    check(!err, "R4", "std read status", err, 0);
    check(n_start == 2 && n_stop == 2, "R4", "two frames per read", n_start * 16 + n_stop, 34);
    check(addr_log.size() == 2 && addr_log[0] == {DEV, 1'b0} && addr_log[1] == {DEV, 1'b1},
          "R4", "header pair", addr_log[0], {DEV, 1'b0});
    check(n_mack == 5 && n_mnack == 1, "R5", "ack all but last", n_mack * 16 + n_mnack, 81);

    // R3: legacy write then legacy read at 0x45
    do_write(1, 8'h45, 3, 8'hC3, 1, err);
    check(!err, "R3", "legacy write status", err, 0);
    check(addr_log[0] == {7'h45, 1'b0}, "R3", "legacy write header", addr_log[0], 8'h8A);
    do_read(1, 8'h45, 3, 1, err);
    check(!err && addr_log[0] == {7'h45, 1'b1}, "R3", "legacy read header", addr_log[0], 8'h8B);
    check(n_start == 1 && n_stop == 1, "R3", "legacy read single frame", n_start * 16 + n_stop, 17);

    // R7: device busy for 3 polls per burst
    busy_set = 3;
    do_write(0, 8'h20, 5, 8'h07, 1, err);
    busy_set = 0;
    check(!err, "R7", "write with busy device", err, 0);
    check(n_busy_nack == 6, "R7", "refused polls", n_busy_nack, 6);
    do_read(0, 8'h20, 5, 1, err);
    check(!err, "R6", "read back after bursts", err, 0);

    // R7: poll limit reached
    busy_set = 1000;
    do_write(0, 8'h30, 2, 8'h90, 1, err);
    busy_set = 0; busy_left = 0;
    check(err, "R7", "poll timeout error", err, 1);
    check(n_busy_nack == POLLS, "R7", "poll attempts", n_busy_nack, POLLS);

    // R8: address not acknowledged
    sl_dev = 7'h51;
    do_read(0, 8'h00, 2, 0, err);
    sl_dev = DEV;
    check(err, "R8", "address nack error", err, 1);
    check(addr_log.size() == 1 && n_stop == 1, "R8", "abort after header", addr_log.size(), 1);

    // R8: data not acknowledged
    nack_data = 1;
    do_write(0, 8'h40, 3, 8'h66, 0, err);
    nack_data = 0;
    wq.delete();
    check(err, "R8", "data nack error", err, 1);
    check(n_bursts == 0 && n_stop == 1 && addr_log.size() == 1, "R8", "no burst, no poll",
          n_bursts, 0);
    do_read(0, 8'h40, 1, 1, err);
    check(!err, "R8", "old byte kept", err, 0);

    // R10: zero length
    run(0, 0, 8'h00, 0, err, took);
    check(!err && took <= 1, "R10", "zero length done", took, 1);
    check(n_start == 0 && n_stop == 0, "R10", "no bus activity", n_start, 0);

    check(pace_viol == 0, "R9", "line change spacing", pace_viol, 0);
    check(exp_q.size() == 0, "R5", "all read bytes delivered", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule